// File: doc/BRIEF.md
# Byte and Word Memory Access Unit

This unit sits in the memory stage of a 32-bit load-store core. Each cycle it may take one access request made of a base register value, a 16-bit signed displacement, the register value to be stored and a 6-bit operation code. It forms the byte address by adding the sign-extended displacement to the base. It then drives a data memory port that is one word wide and has one write enable per byte. Word reads and writes move the full register. Byte stores place the low byte of the register into a single lane. Byte loads pick one lane of the returned word and widen it, with sign or zero fill chosen by the operation code.

Memory is little-endian, so address bits 1:0 name the byte lane. The memory answers a read a fixed number of cycles later, set by the `RD_LAT` parameter. The unit carries the lane and fill choice of each load along a matching pipeline, so loads may issue back to back. A word access whose address is not a multiple of four raises a misalign flag in the request cycle and touches nothing.

Top module: `lsu_unit`

## Requirements
- R1: For a recognised opcode with `req_valid` high, `mem_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32, in the same cycle. This covers negative displacements and carries past bit 31.
- R2: Opcode 35 (word load) at an aligned address asserts `mem_rd_en` with no write enable. `RD_LAT` cycles later `ld_data` equals the memory word unchanged.
- R3: Opcode 43 (word store) at an aligned address asserts all four bits of `mem_wr_en`, drives `mem_wdata` equal to `req_rt_data`, and does not read.
- R4: Opcode 32 (signed byte load) returns byte lane `mem_addr[1:0]` of the word, where lane k is bits 8k+7:8k. Bits 31:8 of the result are copies of that byte's bit 7.
- R5: Opcode 36 (unsigned byte load) returns the same lane with bits 31:8 equal to zero.
- R6: Opcode 40 (byte store) asserts exactly one write enable, bit `mem_addr[1:0]`. It places `req_rt_data[7:0]` in that lane of `mem_wdata`, and the other bytes of the memory word are left unchanged.
- R7: A word load or word store with `mem_addr[1:0]` nonzero sets `misalign` in that cycle, asserts no write enable and no read, and produces no `ld_valid`. The stored word stays unchanged.
- R8: With `req_valid` low, or with an opcode other than the five above, the unit reads nothing, writes nothing and keeps `misalign` low.
- R9: While `rst_n` is low and in the first cycle after it rises with no request, `ld_valid`, `mem_rd_en` and `mem_wr_en` are zero.
- R10: `ld_valid` is high exactly `RD_LAT` cycles after each cycle with `mem_rd_en` high. Back-to-back loads return one result each, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | An access request is present this cycle |
| req_opcode | input | 6 | Operation code of the access |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_rt_data | input | 32 | Register value for stores |
| mem_addr | output | 32 | Effective byte address |
| mem_rd_en | output | 1 | Read strobe to data memory |
| mem_wr_en | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Write data, lane-steered |
| mem_rdata | input | 32 | Read data, `RD_LAT` cycles after the read |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extended load result for the destination register |
| misalign | output | 1 | Unaligned word access was rejected |

## Verification
The bench builds the unit with `RD_LAT` set to 2 and all widths at their defaults. This selects the multi-stage generate variant of the load metadata chain, and it lets two loads be in flight at the same time. So the ordering in R10, and the way lane and fill choice travel with each load, are tested under overlap. The memory model in the bench applies the design's byte enables itself. A byte store that spills into the wrong lane, or a rejected access that still writes, therefore shows up in a later word load.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_LDW,
      ACC_STW,
      ACC_LDB_S,
      ACC_LDB_U,
      ACC_STB
   } acc_kind_e;

   localparam int unsigned OPC_LDW_DEF   = 35;
   localparam int unsigned OPC_STW_DEF   = 43;
   localparam int unsigned OPC_LDB_S_DEF = 32;
   localparam int unsigned OPC_LDB_U_DEF = 36;
   localparam int unsigned OPC_STB_DEF   = 40;

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  disp,
   output logic [ADDR_W-1:0] ea
);
   localparam int unsigned EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign disp_ext = disp;
      end else begin : g_sext
         assign disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
      end
   endgenerate

   assign ea = base + disp_ext;
endmodule

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
#(
   parameter int unsigned OPC_W    = 6,
   parameter int unsigned LANE_W   = 2,
   parameter int unsigned OP_LDW   = OPC_LDW_DEF,
   parameter int unsigned OP_STW   = OPC_STW_DEF,
   parameter int unsigned OP_LDB_S = OPC_LDB_S_DEF,
   parameter int unsigned OP_LDB_U = OPC_LDB_U_DEF,
   parameter int unsigned OP_STB   = OPC_STB_DEF
) (
   input  logic              req_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [LANE_W-1:0] ea_lo,
   output logic              rd_en,
   output logic              wr_word,
   output logic              wr_byte,
   output logic              ld_byte,
   output logic              ld_sext,
   output logic              misalign
);
   acc_kind_e kind;
   logic      word_acc;
   logic      unaligned;
   logic      load_acc;

   always_comb begin
      kind = ACC_NONE;
      if (req_valid) begin
         if      (opcode == OPC_W'(OP_LDW))   kind = ACC_LDW;
         else if (opcode == OPC_W'(OP_STW))   kind = ACC_STW;
         else if (opcode == OPC_W'(OP_LDB_S)) kind = ACC_LDB_S;
         else if (opcode == OPC_W'(OP_LDB_U)) kind = ACC_LDB_U;
         else if (opcode == OPC_W'(OP_STB))   kind = ACC_STB;
      end
   end

   assign word_acc  = (kind == ACC_LDW) || (kind == ACC_STW);
   assign unaligned = |ea_lo;
   assign misalign  = word_acc && unaligned;
   assign load_acc  = (kind == ACC_LDW) || (kind == ACC_LDB_S) || (kind == ACC_LDB_U);

   assign rd_en   = load_acc && !misalign;
   assign wr_word = (kind == ACC_STW) && !misalign;
   assign wr_byte = (kind == ACC_STB);
   assign ld_byte = (kind == ACC_LDB_S) || (kind == ACC_LDB_U);
   assign ld_sext = (kind == ACC_LDB_S);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned LANE_W = $clog2(LANES)
) (
   input  logic              wr_word,
   input  logic              wr_byte,
   input  logic [LANE_W-1:0] lane,
   input  logic [DATA_W-1:0] rt_data,
   output logic [LANES-1:0]  we,
   output logic [DATA_W-1:0] wdata
);
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic hit;
         assign hit            = (lane == LANE_W'(g));
         assign we[g]          = wr_word || (wr_byte && hit);
         assign wdata[8*g +: 8] = wr_word ? rt_data[8*g +: 8] : rt_data[7:0];
      end
   endgenerate
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RD_LAT = 1,
   parameter int unsigned LANES  = DATA_W / 8,
   parameter int unsigned LANE_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              ld_byte,
   input  logic              ld_sext,
   input  logic [LANE_W-1:0] lane,
   input  logic [DATA_W-1:0] rdata,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data
);
   localparam int unsigned META_W = 3 + LANE_W;

   logic [META_W-1:0] meta_in;
   logic [META_W-1:0] meta_out;

   assign meta_in = {rd_en, rd_en && ld_byte, rd_en && ld_sext, lane};

   generate
      if (RD_LAT == 1) begin : g_single
         logic [META_W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= meta_in;
         end
         assign meta_out = stage_q;
      end else begin : g_chain
         logic [META_W-1:0] stage_q [RD_LAT];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < RD_LAT; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= meta_in;
               for (int i = 1; i < RD_LAT; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign meta_out = stage_q[RD_LAT-1];
      end
   endgenerate

   logic              m_vld;
   logic              m_byte;
   logic              m_sext;
   logic [LANE_W-1:0] m_lane;

   assign {m_vld, m_byte, m_sext, m_lane} = meta_out;

   logic [7:0] lane_byte [LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_pick
         assign lane_byte[g] = rdata[8*g +: 8];
      end
   endgenerate

   logic [7:0]        sel_byte;
   logic [DATA_W-1:0] byte_ext;

   assign sel_byte = lane_byte[m_lane];
   assign byte_ext = m_sext ? {{(DATA_W-8){sel_byte[7]}}, sel_byte}
                            : {{(DATA_W-8){1'b0}}, sel_byte};

   assign ld_valid = m_vld;
   assign ld_data  = m_byte ? byte_ext : rdata;
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
   import lsu_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned OFF_W    = 16,
   parameter int unsigned OPC_W    = 6,
   parameter int unsigned RD_LAT   = 1,
   parameter int unsigned OP_LDW   = OPC_LDW_DEF,
   parameter int unsigned OP_STW   = OPC_STW_DEF,
   parameter int unsigned OP_LDB_S = OPC_LDB_S_DEF,
   parameter int unsigned OP_LDB_U = OPC_LDB_U_DEF,
   parameter int unsigned OP_STB   = OPC_STB_DEF,
   localparam int unsigned LANES   = DATA_W / 8,
   localparam int unsigned LANE_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [OPC_W-1:0]  req_opcode,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [DATA_W-1:0] req_rt_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   output logic [LANES-1:0]  mem_wr_en,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data,
   output logic              misalign
);
   // elaboration-time parameter checks
   generate
      if (DATA_W % 8 != 0 || LANES < 2) begin : g_bad_data_w
         $error("lsu_unit: DATA_W must be a multiple of 8, at least 16");
      end
      if ((LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("lsu_unit: lane count must be a power of two");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("lsu_unit: RD_LAT must be at least 1");
      end
      if (OFF_W > ADDR_W || OFF_W < 1) begin : g_bad_off
         $error("lsu_unit: OFF_W must lie in 1..ADDR_W");
      end
      if (ADDR_W < LANE_W) begin : g_bad_addr
         $error("lsu_unit: ADDR_W too small for lane select");
      end
      if (OP_LDW >= (1 << OPC_W) || OP_STW >= (1 << OPC_W) || OP_LDB_S >= (1 << OPC_W)
          || OP_LDB_U >= (1 << OPC_W) || OP_STB >= (1 << OPC_W)) begin : g_bad_opw
         $error("lsu_unit: an opcode does not fit OPC_W");
      end
      if (OP_LDW == OP_STW || OP_LDW == OP_LDB_S || OP_LDW == OP_LDB_U || OP_LDW == OP_STB
          || OP_STW == OP_LDB_S || OP_STW == OP_LDB_U || OP_STW == OP_STB
          || OP_LDB_S == OP_LDB_U || OP_LDB_S == OP_STB || OP_LDB_U == OP_STB) begin : g_dup_op
         $error("lsu_unit: opcodes must be distinct");
      end
   endgenerate

   logic [ADDR_W-1:0] ea;
   logic              rd_en;
   logic              wr_word;
   logic              wr_byte;
   logic              ld_byte;
   logic              ld_sext;
   logic              mis;
   logic [LANE_W-1:0] lane;

   lsu_agen #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W)
   ) u_agen (
      .base (req_base),
      .disp (req_offset),
      .ea   (ea)
   );

   assign lane = ea[LANE_W-1:0];

   lsu_decode #(
      .OPC_W    (OPC_W),
      .LANE_W   (LANE_W),
      .OP_LDW   (OP_LDW),
      .OP_STW   (OP_STW),
      .OP_LDB_S (OP_LDB_S),
      .OP_LDB_U (OP_LDB_U),
      .OP_STB   (OP_STB)
   ) u_decode (
      .req_valid (req_valid),
      .opcode    (req_opcode),
      .ea_lo     (lane),
      .rd_en     (rd_en),
      .wr_word   (wr_word),
      .wr_byte   (wr_byte),
      .ld_byte   (ld_byte),
      .ld_sext   (ld_sext),
      .misalign  (mis)
   );

   lsu_store_lane #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_store (
      .wr_word (wr_word),
      .wr_byte (wr_byte),
      .lane    (lane),
      .rt_data (req_rt_data),
      .we      (mem_wr_en),
      .wdata   (mem_wdata)
   );

   lsu_load_align #(
      .DATA_W (DATA_W),
      .RD_LAT (RD_LAT),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_load (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .ld_byte  (ld_byte),
      .ld_sext  (ld_sext),
      .lane     (lane),
      .rdata    (mem_rdata),
      .ld_valid (ld_valid),
      .ld_data  (ld_data)
   );

   assign mem_addr  = ea;
   assign mem_rd_en = rd_en;
   assign misalign  = mis;
endmodule

// File: rtl/lsu_unit_chk.sv
module lsu_unit_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OPC_W  = 6,
   parameter int unsigned RD_LAT = 1,
   parameter int unsigned OP_STW = 43,
   parameter int unsigned OP_STB = 40,
   parameter int unsigned LANES  = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [OPC_W-1:0]  req_opcode,
   input logic [DATA_W-1:0] req_rt_data,
   input logic              mem_rd_en,
   input logic [LANES-1:0]  mem_wr_en,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              ld_valid,
   input logic              misalign
);
   logic [RD_LAT-1:0] rd_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_hist <= '0;
      else        rd_hist <= (rd_hist << 1) | RD_LAT'(mem_rd_en);
   end

   // R10: a result appears exactly RD_LAT cycles after each read
   p_ld_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid == rd_hist[RD_LAT-1]);

   // R8: reading and writing never happen in one cycle
   p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && (|mem_wr_en)));

   // R8: an idle request port leaves memory alone
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!mem_rd_en && mem_wr_en == '0 && !misalign));

   // R6: a byte store enables a single lane
   p_byte_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_opcode == OPC_W'(OP_STB)) |-> ($countones(mem_wr_en) == 1));

   // R3: an aligned word store writes every lane with the register value
   p_word_store_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_opcode == OPC_W'(OP_STW) && !misalign)
         |-> (mem_wr_en == {LANES{1'b1}} && mem_wdata == req_rt_data));

   // R7: a rejected access neither reads nor writes
   p_misalign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_rd_en && mem_wr_en == '0));
endmodule

bind lsu_unit lsu_unit_chk #(
   .DATA_W (DATA_W),
   .OPC_W  (OPC_W),
   .RD_LAT (RD_LAT),
   .OP_STW (OP_STW),
   .OP_STB (OP_STB),
   .LANES  (LANES)
) u_lsu_unit_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_opcode  (req_opcode),
   .req_rt_data (req_rt_data),
   .mem_rd_en   (mem_rd_en),
   .mem_wr_en   (mem_wr_en),
   .mem_wdata   (mem_wdata),
   .ld_valid    (ld_valid),
   .misalign    (misalign)
);

// File: tb/test_lsu_unit.sv
module test_lsu_unit;
   localparam int unsigned LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_opcode = '0;
   logic [31:0] req_base = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] req_rt_data = '0;
   logic [31:0] mem_addr;
   logic        mem_rd_en;
   logic [3:0]  mem_wr_en;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        ld_valid;
   logic [31:0] ld_data;
   logic        misalign;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   lsu_unit #(.RD_LAT(LAT)) i_lsu_unit (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_opcode (req_opcode),
      .req_base (req_base), .req_offset (req_offset), .req_rt_data (req_rt_data),
      .mem_addr (mem_addr), .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .ld_valid (ld_valid),
      .ld_data (ld_data), .misalign (misalign)
   );

   // memory model driven only by the design's port
   logic [31:0] mem    [64];
   logic [31:0] shadow [64];
   logic [31:0] rpipe0 = '0;
   logic [31:0] rpipe1 = '0;

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]    = '0;
         shadow[i] = '0;
      end
   end

   always @(posedge clk) begin
      for (int k = 0; k < 4; k++)
         if (mem_wr_en[k]) mem[mem_addr[7:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
      rpipe0 <= mem_rd_en ? mem[mem_addr[7:2]] : 32'h0;
      rpipe1 <= rpipe0;
   end
   assign mem_rdata = rpipe1;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always @(negedge clk) begin
      #3;
      if (rst_n && ld_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected result", ld_data, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(ld_data === e, t, ld_data, e);
         end
      end
   end

   task automatic req(input bit vld, input int op, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] rt);
      logic [31:0] ea;
      logic [5:0]  idx;
      int          ln;
      bit          e_rd;
      bit          e_mis;
      logic [3:0]  e_we;
      string       tag;
      logic [7:0]  b;
      @(negedge clk);
      req_valid   = vld;
      req_opcode  = 6'(op);
      req_base    = base;
      req_offset  = off;
      req_rt_data = rt;
      #1;
      ea    = base + {{16{off[15]}}, off};
      idx   = ea[7:2];
      ln    = int'(ea[1:0]);
      e_rd  = 1'b0;
      e_mis = 1'b0;
      e_we  = 4'h0;
      tag   = "R8";
      if (vld) begin
         case (op)
            35: begin tag = "R2"; e_mis = (ea[1:0] != 0); e_rd = !e_mis; end
            43: begin tag = "R3"; e_mis = (ea[1:0] != 0); e_we = e_mis ? 4'h0 : 4'hF; end
            32: begin tag = "R4"; e_rd = 1'b1; end
            36: begin tag = "R5"; e_rd = 1'b1; end
            40: begin tag = "R6"; e_we = 4'(1 << ln); end
            default: tag = "R8";
         endcase
         if (e_mis) tag = "R7";
      end
      if (tag != "R8" && tag != "R7") check(mem_addr === ea, "R1 address", mem_addr, ea);
      check(mem_rd_en === e_rd, {tag, " read strobe"}, 32'(mem_rd_en), 32'(e_rd));
      check(mem_wr_en === e_we, {tag, " write enables"}, 32'(mem_wr_en), 32'(e_we));
      check(misalign === e_mis, {tag, " misalign flag"}, 32'(misalign), 32'(e_mis));
      if (tag == "R3") check(mem_wdata === rt, "R3 write data", mem_wdata, rt);
      if (tag == "R6") check(mem_wdata[8*ln +: 8] === rt[7:0], "R6 lane data",
                             32'(mem_wdata[8*ln +: 8]), 32'(rt[7:0]));
      // expected state and results from the requirements
      if (tag == "R3") shadow[idx] = rt;
      if (tag == "R6") shadow[idx][8*ln +: 8] = rt[7:0];
      if (tag == "R2") begin exp_q.push_back(shadow[idx]); tag_q.push_back("R2 word load"); end
      if (tag == "R4") begin
         b = shadow[idx][8*ln +: 8];
         exp_q.push_back({{24{b[7]}}, b});
         tag_q.push_back("R4 signed byte load");
      end
      if (tag == "R5") begin
         b = shadow[idx][8*ln +: 8];
         exp_q.push_back({24'h0, b});
         tag_q.push_back("R5 unsigned byte load");
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(ld_valid === 1'b0, "R9 ld_valid in reset", 32'(ld_valid), 32'h0);
      check(mem_wr_en === 4'h0, "R9 write enables in reset", 32'(mem_wr_en), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(ld_valid === 1'b0, "R9 ld_valid after reset", 32'(ld_valid), 32'h0);
      check(mem_rd_en === 1'b0, "R9 read strobe after reset", 32'(mem_rd_en), 32'h0);

      // R3 word stores; R1 negative, wrapping and plain displacements
      req(1, 43, 32'h0000_2000, 16'hE000, 32'h1122_3344);
      req(1, 43, 32'hFFFF_FFF8, 16'h000C, 32'h80FF_7F01);
      req(1, 43, 32'h0000_0100, 16'hFF08, 32'hDEAD_BEEF);
      req(1, 43, 32'h0000_000C, 16'h0000, 32'h0F0F_F0F0);
      // R2 / R10 back-to-back word loads
      req(1, 35, 32'h0000_0000, 16'h0000, 32'h0);
      req(1, 35, 32'h0000_1004, 16'hF000, 32'h0);
      req(1, 35, 32'h0000_0008, 16'h0000, 32'h0);
      req(1, 35, 32'h0000_0010, 16'hFFFC, 32'h0);
      // R4 and R5 on every lane of 0x80FF7F01
      for (int k = 0; k < 4; k++) req(1, 32, 32'h0000_0004, 16'(k), 32'h0);
      for (int k = 0; k < 4; k++) req(1, 36, 32'h0000_0004, 16'(k), 32'h0);
      // R6 byte stores into an empty word, then read it back
      for (int k = 0; k < 4; k++) req(1, 40, 32'h0000_0010, 16'(k), 32'hAABB_CC00 | 32'(k + 8'hA0));
      req(1, 40, 32'h0000_0015, 16'h0001, 32'h1234_5677);
      req(1, 35, 32'h0000_0010, 16'h0000, 32'h0);
      req(1, 35, 32'h0000_0014, 16'h0000, 32'h0);
      // R7 misaligned word store and load, followed by proof of no change
      req(1, 43, 32'h0000_0004, 16'h0001, 32'hFFFF_FFFF);
      req(1, 43, 32'h0000_0008, 16'h0003, 32'hFFFF_FFFF);
      req(1, 35, 32'h0000_0006, 16'h0000, 32'h0);
      req(1, 35, 32'h0000_0004, 16'h0000, 32'h0);
      req(1, 35, 32'h0000_0008, 16'h0000, 32'h0);
      // R8 unknown opcode and dropped valid
      req(1, 0,  32'h0000_000C, 16'h0000, 32'h5555_5555);
      req(0, 43, 32'h0000_000C, 16'h0000, 32'h5555_5555);
      req(0, 40, 32'h0000_000C, 16'h0000, 32'h5555_5555);
      req(1, 35, 32'h0000_000C, 16'h0000, 32'h0);
      idle(LAT + 3);
      check(exp_q.size() == 0, "R10 all loads returned", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule